// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory. A request carries the virtual address, whether the access is a store, and whether it comes from user mode. The top ten address bits select an entry in the first-level table. A base address input locates that table. The entry it reads names the frame that holds a second-level table. The next ten bits select an entry in that table. The final entry supplies the physical frame, and the low twelve bits pass through unchanged, since pages are 4 KB.

Each read goes out as a one-cycle request on a simple memory port. The block then waits for a response strobe that carries the 32-bit entry. A walk ends in one of two ways: a physical address, or a fault code telling why translation failed. The block handles one walk at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: The first read of a walk targets `pt_base + 4*va[31:22]`, using the base value present when the request was accepted.
- R3: The second read targets `{pte1[31:12], 12'h000} + 4*va[21:12]`, where `pte1` is the first-level entry.
- R4: Entry layout: bit 0 is valid, bit 1 is user-accessible, bit 2 is writable, bits 31:12 are the frame number. The access-rights bits of a first-level entry have no effect on the result.
- R5: A first-level entry with valid = 0 ends the walk with `fault` = 1 after exactly one memory read.
- R6: A second-level entry with valid = 0 ends the walk with `fault` = 2 after two reads.
- R7: If the second-level entry is valid, the walk ends with `fault` = 3 in either case: a store to an entry whose writable bit is 0, or a user access to an entry whose user bit is 0.
- R8: A walk that does not fault ends with `fault` = 0 and `paddr` = `{pte2[31:12], va[11:0]}`. When a walk faults, `paddr` is 0.
- R9: A request is accepted only when `req_ready` is 1. A request presented while a walk is running has no effect on that walk's result.
- R10: `done` is high for exactly one cycle per walk. `req_ready` is back at 1 in that same cycle.
- R11: `mem_req` is high for one cycle per read. A response strobe that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Physical address of the first-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 for a store access |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Address of the entry being read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Page table entry returned |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 ok, 1 first level absent, 2 second level absent, 3 rights violation |
| paddr | output | 32 | Translated physical address, 0 on fault |

## Verification
The assertions rely on three properties of the memory side. Each read is answered by exactly one response strobe. That strobe comes after the request. No second read is issued before the first is answered. The bench's memory model is the only source of response strobes, and it answers each request once, after a latency of zero to two cycles. The one stray strobe the bench injects is sent while the walker is idle, which keeps every other strobe tied to a real read. Table contents are computed arithmetically from the address, so every first-level index is swept and the expected faults and addresses are derived from the same formulas.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] pt_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_store,
  input  logic            req_user,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            done,
  output logic [1:0]      fault,
  output logic [VA_W-1:0] paddr
);
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int FRM_W = VA_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2} state_t;

  state_t            st;
  logic [VA_W-1:0]   va_q, base_q, paddr_q;
  logic [FRM_W-1:0]  tbl_q;
  logic              store_q, user_q, done_q;
  logic [1:0]        fault_q;

  wire [IDX_W-1:0] idx1 = va_q[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0] idx2 = va_q[OFF_W+IDX_W-1 -: IDX_W];
  wire [VA_W-1:0]  off1 = VA_W'({idx1, 2'b00});
  wire [VA_W-1:0]  off2 = VA_W'({idx2, 2'b00});

  wire pte_v = mem_rsp_data[0];
  wire pte_u = mem_rsp_data[1];
  wire pte_w = mem_rsp_data[2];
  wire deny  = (store_q && !pte_w) || (user_q && !pte_u);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_RD1) || (st == S_RD2);
  assign mem_addr  = (st == S_RD1) ? base_q + off1 : {tbl_q, {OFF_W{1'b0}}} + off2;
  assign done      = done_q;
  assign fault     = fault_q;
  assign paddr     = paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      store_q <= 1'b0;
      user_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 2'd0;
      paddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          base_q  <= pt_base;
          store_q <= req_store;
          user_q  <= req_user;
          st      <= S_RD1;
        end
        S_RD1: st <= S_WT1;
        S_WT1: if (mem_rsp_valid) begin
          if (!pte_v) begin
            done_q  <= 1'b1;
            fault_q <= 2'd1;
            paddr_q <= '0;
            st      <= S_IDLE;
          end else begin
            tbl_q <= mem_rsp_data[VA_W-1:OFF_W];
            st    <= S_RD2;
          end
        end
        S_RD2: st <= S_WT2;
        S_WT2: if (mem_rsp_valid) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (!pte_v) begin
            fault_q <= 2'd2;
            paddr_q <= '0;
          end else if (deny) begin
            fault_q <= 2'd3;
            paddr_q <= '0;
          end else begin
            fault_q <= 2'd0;
            paddr_q <= {mem_rsp_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  a_r9_accept_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (mem_req && !req_ready));
  a_r8_fault_clears_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> paddr == '0);
  a_r2_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(req_ready) && $past(req_valid)) |-> mem_addr[1:0] == $past(pt_base[1:0]));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h0040_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] paddr;

  int vectors = 0, errors = 0;
  int nreq = 0, bad_addr = 0;
  int lat = 0;
  logic stray = 1'b0;
  logic pend = 1'b0;
  int cnt = 0;
  logic [31:0] addr_p = '0;

  localparam logic [31:0] BASE = 32'h0040_0000;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_user(req_user),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .paddr(paddr)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a, output logic ok);
    logic [9:0] i1, t, i2;
    logic [1:0] r;
    logic v;
    ok = 1'b1;
    if (a[31:12] == BASE[31:12] && a[1:0] == 2'b00) begin
      i1 = a[11:2];
      v  = (i1 % 7) != 3;
      return {20'h01000 + 20'(i1), 9'd0, i1[1:0], v};
    end else if (a[31:22] == 10'h004 && a[1:0] == 2'b00) begin
      t  = a[21:12];
      i2 = a[11:2];
      v  = ((int'(i2) + int'(t)) % 5) != 0;
      r  = i2[1:0] ^ t[1:0];
      return {20'h80000 ^ {t, i2}, 9'd0, r[1], r[0], v};
    end
    ok = 1'b0;
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    logic ok;
    logic [31:0] w;
    mem_rsp_valid <= 1'b0;
    if (stray) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= 32'h8000_0007;
    end
    if (pend) begin
      if (cnt == 0) begin
        w = mem_word(addr_p, ok);
        if (!ok) begin
          bad_addr <= bad_addr + 1;
          $display("FAIL R2/R3: read from unmapped address %h (expected a table entry address)", addr_p);
        end
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= w;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_req) begin
      pend   <= 1'b1;
      cnt    <= lat;
      addr_p <= mem_addr;
      nreq   <= nreq + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic st, input logic us);
    logic [9:0] i1, i2;
    logic [1:0] r;
    logic v1, v2, deny;
    logic [1:0] ef;
    logic [31:0] ep;
    int n0, en, waitc;
    i1 = va[31:22];
    i2 = va[21:12];
    v1 = (i1 % 7) != 3;
    v2 = ((int'(i2) + int'(i1)) % 5) != 0;
    r  = i2[1:0] ^ i1[1:0];
    deny = (st && !r[1]) || (us && !r[0]);
    ep = 32'h0;
    if (!v1) begin ef = 2'd1; en = 1; end
    else if (!v2) begin ef = 2'd2; en = 2; end
    else if (deny) begin ef = 2'd3; en = 2; end
    else begin ef = 2'd0; en = 2; ep = {20'h80000 ^ {i1, i2}, va[11:0]}; end
    @(negedge clk);
    n0 = nreq;
    req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = us;
    @(negedge clk);
    req_vaddr = ~va; req_store = ~st; req_user = ~us;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!done && waitc < 40) begin @(negedge clk); waitc++; end
    if (!done) begin
      vectors++; errors++;
      $display("FAIL R10: actual no done expected done for va %h", va);
      return;
    end
    if (ef == 2'd1) check("R5 fault", 32'(fault), 32'(ef));
    else if (ef == 2'd2) check("R6 fault", 32'(fault), 32'(ef));
    else if (ef == 2'd3) check("R7 fault", 32'(fault), 32'(ef));
    else check("R4/R9 fault", 32'(fault), 32'(ef));
    check("R8 paddr", paddr, ep);
    check("R3/R5 read count", 32'(nreq - n0), 32'(en));
    check("R10 ready at done", 32'(req_ready), 32'd1);
    @(negedge clk);
    check("R10 done pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors + bad_addr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 mem_req after reset", 32'(mem_req), 32'd0);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    check("R11 stray response done", 32'(done), 32'd0);
    check("R11 stray response ready", 32'(req_ready), 32'd1);
    check("R11 stray response read", 32'(mem_req), 32'd0);
    check("R11 stray response reads", 32'(nreq), 32'd0);
    for (int i1 = 0; i1 < 1024; i1++) begin
      for (int k = 0; k < 2; k++) begin
        logic [9:0] i2;
        logic [11:0] off;
        i2  = 10'((i1 * 37 + k * 511) % 1024);
        off = 12'((i1 * 13 + k * 1031) % 4096);
        lat = (i1 + k) % 3;
        for (int acc = 0; acc < 4; acc++)
          walk({10'(i1), i2, off}, acc[1], acc[0]);
      end
    end
    check("R2/R3 table addresses", 32'(bad_addr), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors + bad_addr);
    $finish;
  end
endmodule